// File: doc/BRIEF.md
# PWM Phase-Shift Restart Controller

This block fixes where a sinusoidal PWM pattern sits relative to the mains voltage. It does this with a count, compare and restart scheme. Each rising edge of the mains-synchronous reference restarts two angle counters. They advance one phase step per prescaler period, which is one degree of the mains cycle by default.

The lag counter counts upward, so it holds the angle elapsed since the edge. The lead counter counts downward from a full cycle, so it holds the angle still to go before the next edge. Each counter compares its value with its own programmed angle. The counter picked by the mode select drives a single-clock restart pulse, and that pulse resets every downstream PWM module so the pattern begins at the chosen displacement.

Programming both angles to zero, or both to half a cycle, puts the pattern in phase with the reference. Angle words and the mode select are captured only at a reference edge.

Top module: `pwm_phase_restart`

## Requirements
- R1: After reset `restart_o` is low. No pulse appears before the first rising edge of `ref_in` is seen. The edge register resets as if the reference were already high, so a reference held high through reset does not count as an edge.
- R2: A rising edge is the first clock at which `ref_in` is sampled high after being sampled low; call that clock edge E. At E the prescaler and both counters restart and the phase step count begins again from zero.
- R3: With `lag_sel` = 1 (lag mode) and lag angle k, `restart_o` is high during the clock that follows edge E + PRESCALE*k.
- R4: With `lag_sel` = 0 (lead mode) and lead angle k, the pulse follows edge E + PRESCALE*((STEPS - k) mod STEPS).
- R5: Each pulse lasts exactly one clock, and there is at most one pulse per reference period.
- R6: An angle word above STEPS-1 is treated as STEPS-1.
- R7: `lag_sel`, `lead_angle` and `lag_angle` are captured at E only. Changing them later in the period has no effect until the next edge.
- R8: An angle of 0 in either mode gives a pulse right after E, which is in phase. An angle of STEPS/2 in either mode gives the same instant in both modes.
- R9: After the last step, STEPS-1, the counters hold and issue no further pulse until the next edge, however long the period lasts.
- R10: A reference edge arriving before the pulse for the current period discards that pending pulse and restarts timing from the new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Mains-locked main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Mains-synchronous reference square wave |
| lag_sel | input | 1 | Mode select: 1 = lag counter, 0 = lead counter |
| lead_angle | input | $clog2(STEPS) | Lead displacement in phase steps |
| lag_angle | input | $clog2(STEPS) | Lag displacement in phase steps |
| restart_o | output | 1 | One-clock restart pulse to the PWM modules |

## Verification
Two functions can act in the same clock: capturing new settings at a reference edge, and issuing the pulse for step zero. Every period of the sweep sets the angles and mode just before the edge and then scrambles them one clock after it. The single pulse must therefore land where the captured values predict, and angle 0 checks the edge-cycle pulse directly. Sweeping every angle word in both modes, including words that clamp, tests restart timing against an arithmetic model. Short and over-long periods test discarding a pending pulse and holding after the last step.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic {
        MODE_LEAD = 1'b0,
        MODE_LAG  = 1'b1
    } mode_e;
endpackage

// File: rtl/pps_ref_edge.sv
module pps_ref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic edge_o
);
    typedef struct packed {
        logic lvl;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.lvl = ref_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{lvl: 1'b1};
        else        s_q <= s_d;
    end

    assign edge_o = ref_i & ~s_q.lvl;

    AST_EDGE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R2
endmodule

// File: rtl/pps_step_prescaler.sv
module pps_step_prescaler #(
    parameter int PRESCALE = 546
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
    localparam logic [PW-1:0] ONE  = PW'(1);

    typedef struct packed {
        logic [PW-1:0] div;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart_i)            s_d.div = '0;
        else if (s_q.div == LAST) s_d.div = '0;
        else                      s_d.div = s_q.div + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = (s_q.div == LAST);

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.div <= LAST); // R2
    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (s_q.div == '0)); // R2
endmodule

// File: rtl/pps_angle_counter.sv
module pps_angle_counter #(
    parameter int STEPS = 360,
    parameter bit DOWN  = 1'b0,
    localparam int W    = $clog2(STEPS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic         tick_i,
    input  logic [W-1:0] preset_i,
    output logic         hit_o
);
    localparam logic [W-1:0] LAST = W'(STEPS - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] preset;
        logic         armed;
        logic         hit;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic [W-1:0] nxt;
    logic         at_end;

    generate
        if (DOWN) begin : g_down
            assign nxt    = (s_q.cnt == '0) ? LAST : s_q.cnt - ONE;
            assign at_end = (s_q.cnt == ONE);
        end else begin : g_up
            assign nxt    = s_q.cnt + ONE;
            assign at_end = (s_q.cnt == LAST);
        end
    endgenerate

    always_comb begin
        s_d     = s_q;
        s_d.hit = 1'b0;
        if (restart_i) begin
            s_d.cnt    = '0;
            s_d.preset = preset_i;
            s_d.armed  = 1'b1;
            s_d.hit    = (preset_i == '0);
        end else if (s_q.armed && tick_i && !at_end) begin
            s_d.cnt = nxt;
            s_d.hit = (nxt == s_q.preset);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_o = s_q.hit;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST); // R9
    AST_HIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hit |-> (s_q.cnt == s_q.preset && s_q.armed)); // R3
    AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> $stable(s_q.preset)); // R7
    AST_PRESET_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.preset <= LAST); // R6
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (s_q.cnt == '0)); // R2
endmodule

// File: rtl/pwm_phase_restart.sv
module pwm_phase_restart #(
    parameter int STEPS    = 360,
    parameter int PRESCALE = 546,
    localparam int AW      = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic          lag_sel,
    input  logic [AW-1:0] lead_angle,
    input  logic [AW-1:0] lag_angle,
    output logic          restart_o
);
    import pps_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(STEPS - 1);

    typedef struct packed {
        mode_e mode;
    } ctl_st_t;

    ctl_st_t s_d, s_q;
    logic ref_edge;
    logic step_tick;
    logic hit_lead, hit_lag;
    logic [AW-1:0] lead_clamped, lag_clamped;

    pps_ref_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_in),
        .edge_o (ref_edge)
    );

    pps_step_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ref_edge),
        .tick_o    (step_tick)
    );

    assign lead_clamped = (lead_angle > LAST) ? LAST : lead_angle;
    assign lag_clamped  = (lag_angle  > LAST) ? LAST : lag_angle;

    pps_angle_counter #(.STEPS(STEPS), .DOWN(1'b1)) u_cnt_lead (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ref_edge),
        .tick_i    (step_tick),
        .preset_i  (lead_clamped),
        .hit_o     (hit_lead)
    );

    pps_angle_counter #(.STEPS(STEPS), .DOWN(1'b0)) u_cnt_lag (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ref_edge),
        .tick_i    (step_tick),
        .preset_i  (lag_clamped),
        .hit_o     (hit_lag)
    );

    always_comb begin
        s_d = s_q;
        if (ref_edge) s_d.mode = lag_sel ? MODE_LAG : MODE_LEAD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{mode: MODE_LEAD};
        else        s_q <= s_d;
    end

    assign restart_o = (s_q.mode == MODE_LAG) ? hit_lag : hit_lead;

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o); // R5
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_edge |=> $stable(s_q.mode)); // R7
endmodule

// File: tb/pwm_phase_restart_tb_top.sv
module pwm_phase_restart_tb_top;
    localparam int STEPS    = 24;
    localparam int PRESCALE = 3;
    localparam int AW       = $clog2(STEPS);
    localparam int PERIOD   = STEPS * PRESCALE + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic lag_sel = 1'b0;
    logic [AW-1:0] lead_angle = '0;
    logic [AW-1:0] lag_angle = '0;
    logic restart_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_phase_restart #(.STEPS(STEPS), .PRESCALE(PRESCALE)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .lag_sel    (lag_sel),
        .lead_angle (lead_angle),
        .lag_angle  (lag_angle),
        .restart_o  (restart_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One reference period: the settings are applied before the edge and scrambled after it.
    task automatic run_period(input bit sel, input int ang, input int len, input string tag);
        int cnt = 0;
        int pos = -1;
        int clamped = (ang > STEPS - 1) ? STEPS - 1 : ang;
        int k = sel ? clamped : (STEPS - clamped) % STEPS;
        int exp_pos = PRESCALE * k;
        int exp_cnt = (exp_pos < len) ? 1 : 0;
        lag_sel    = sel;
        lead_angle = sel ? AW'((ang + 5) % 32) : AW'(ang);
        lag_angle  = sel ? AW'(ang) : AW'((ang + 7) % 32);
        ref_in     = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (restart_o) begin
                cnt++;
                if (pos < 0) pos = i;
            end
            if (i == 1) begin
                lag_sel    = ~sel;
                lead_angle = ~lead_angle;
                lag_angle  = ~lag_angle;
            end
            if (i == len / 2) ref_in = 1'b0;
        end
        check(cnt == exp_cnt, {tag, " pulse count"}, cnt, exp_cnt);
        if (exp_cnt == 1) check(pos == exp_pos, {tag, " pulse position"}, pos, exp_pos);
    endtask

    initial begin : watchdog
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int pulses;
        repeat (3) @(negedge clk);
        check(restart_o == 1'b0, "R1 reset level", int'(restart_o), 0);
        rst_n = 1'b1;
        // R1: no edge yet, angle 0 programmed: no pulse
        pulses = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (restart_o) pulses++;
        end
        check(pulses == 0, "R1 no pulse before first edge", pulses, 0);

        // R3 R4 R6 R7 R8: sweep every angle word in both modes
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 32; a++) begin
                string tag = $sformatf("%s%s%s R5 R7 R2 sel=%0d ang=%0d",
                    s ? "R3" : "R4",
                    (a > STEPS - 1) ? " R6" : "",
                    (a == 0 || a == STEPS / 2) ? " R8" : "",
                    s, a);
                run_period(s[0], a, PERIOD, tag);
            end
        end

        // R9: very long period, only one pulse
        run_period(1'b1, 0, PERIOD * 3, "R9 lag hold");
        run_period(1'b0, 1, PERIOD * 3, "R9 lead hold");
        // R10: early edge discards the pending pulse, then timing restarts
        run_period(1'b1, 20, 30, "R10 short period");
        run_period(1'b1, 20, PERIOD, "R10 after restart");
        run_period(1'b0, 4, 40, "R10 short lead");
        run_period(1'b0, 4, PERIOD, "R10 lead after restart");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule